// File: doc/BRIEF.md
# Tag-Synchronized Quadrature Down-Mixer

This block mixes one channel of signed ADC samples down to baseband. A numerically controlled oscillator, built from a 32-bit phase accumulator and a quarter-wave sine table, supplies cosine and sine values. Each incoming sample is multiplied by both of them, which gives an in-phase (I) and a quadrature (Q) product on every clock. The filtering that follows is outside this block.

Software loads four oscillator frequency words and an oscillator select into holding registers through a simple write port. None of these writes reaches the datapath until a double-tag strobe copies the whole holding set into the active set. This lets a harmonic change be staged while the channel runs and then applied at a known instant. A separate single-tag strobe forces the oscillator phase back to zero, so the phase of every channel driven by the same tags stays coherent. A channel enable blanks the outputs.

Top module: `ddmix_top`

## Requirements
- R1: While reset is high and on the first clock after it, both outputs are zero. Reset clears all four active frequency words, the active select (to 0) and the phase accumulator.
- R2: On each clock edge the phase accumulator adds the active frequency word chosen by the active select, wrapping modulo 2^32. Its upper 10 bits form the phase index p used for the sample presented in the cycle before that edge.
- R3: A write with `cfg_addr` 0..3 loads `cfg_data` into the holding word of oscillator 0..3. `cfg_addr` 4 loads `cfg_data[1:0]` into the holding select. Holding writes alone never change the outputs.
- R4: At an edge where `dtag_in` is high, every holding word and the holding select are copied to the active set. The accumulator increment at that same edge still uses the previous active word. A write at that same edge lands only in the holding set.
- R5: At an edge where `tag_in` is high, the accumulator becomes zero, so the next sample uses p = 0.
- R6: When `tag_in` and `dtag_in` are high in the same cycle, both take effect at that edge. The next sample uses p = 0, and the sample after it uses the phase of the newly committed word.
- R7: The oscillator sine for index p is round(32767 * sin(2*pi*(p+0.5)/1024)), rounding half away from zero. The cosine for index p is the sine for index (p+256) mod 1024.
- R8: `i_out` = sample * cosine and `q_out` = sample * sine, as 30-bit signed values. A sample presented before rising edge n appears on the outputs just after edge n+2.
- R9: A sample presented while `ch_en` is low produces zero on both outputs at its output slot. Samples presented while it is high are not affected.
- R10: Full-scale samples (-8192 and +8191) at peak oscillator amplitude produce exact products without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 14 | Two's complement ADC sample |
| ch_en | input | 1 | Channel enable, aligned with the sample |
| tag_in | input | 1 | Single-tag strobe: clears oscillator phase |
| dtag_in | input | 1 | Double-tag strobe: commits holding registers |
| cfg_wr | input | 1 | Holding register write strobe |
| cfg_addr | input | 3 | 0..3 frequency word, 4 oscillator select |
| cfg_data | input | 32 | Write data |
| i_out | output | 30 | In-phase product |
| q_out | output | 30 | Quadrature product |

## Verification
The phase clear and the parameter commit can land on the same edge. A configuration write can also coincide with a commit. The bench drives `tag_in` and `dtag_in` high together after staging a new word and select, and a separate step writes a holding word in the very cycle of a commit. A cycle-accurate reference model predicts every output slot, so these cases are judged by the exact products in the slots around the event: phase zero first, the new increment after that, and the holding-only write not appearing until the next commit.

// File: rtl/ddmix_pkg.sv
package ddmix_pkg;

    localparam int SAMPLE_W = 14;
    localparam int PHASE_W  = 32;
    localparam int LUT_AW   = 10;
    localparam int AMP_W    = 16;
    localparam int NUM_LO   = 4;
    localparam int ADDR_W   = 3;

    localparam int SEL_W    = $clog2(NUM_LO);
    localparam int PROD_W   = SAMPLE_W + AMP_W;
    localparam int QTR_AW   = LUT_AW - 2;
    localparam int QTR_N    = 1 << QTR_AW;
    localparam int AMP_MAX  = (1 << (AMP_W - 1)) - 1;

    typedef logic [PHASE_W-1:0] fword_t;

    typedef struct packed {
        fword_t [NUM_LO-1:0] fw;
        logic   [SEL_W-1:0]  sel;
    } lo_cfg_t;

    typedef struct packed {
        logic signed [AMP_W-1:0] cos_v;
        logic signed [AMP_W-1:0] sin_v;
    } lo_pair_t;

    typedef struct packed {
        logic signed [PROD_W-1:0] i;
        logic signed [PROD_W-1:0] q;
    } iq_t;

    // First quadrant of the sine, sampled at half-step offsets so that
    // mirroring the index gives an exact quarter-wave symmetry.
    function automatic logic [QTR_N*AMP_W-1:0] build_quarter();
        logic [QTR_N*AMP_W-1:0] tbl;
        real arg;
        int  v;
        tbl = '0;
        for (int k = 0; k < QTR_N; k++) begin
            arg = 2.0 * 3.14159265358979323846 * (real'(k) + 0.5) / real'(4 * QTR_N);
            v   = $rtoi(real'(AMP_MAX) * $sin(arg) + 0.5);
            tbl[k*AMP_W +: AMP_W] = AMP_W'(v);
        end
        return tbl;
    endfunction

endpackage

// File: rtl/ddmix_regs.sv
module ddmix_regs
    import ddmix_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PHASE_W-1:0] wr_data,
    input  logic              commit,
    output lo_cfg_t           active
);

    lo_cfg_t hold;

    for (genvar g = 0; g < NUM_LO; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                hold.fw[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(g))
                hold.fw[g] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold.sel <= '0;
        else if (wr_en && wr_addr == ADDR_W'(NUM_LO))
            hold.sel <= wr_data[SEL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            active <= '0;
        else if (commit)
            active <= hold;
    end

    AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (rst)
        commit |=> active == $past(hold)); // R4

    AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active)); // R3

endmodule

// File: rtl/ddmix_nco.sv
module ddmix_nco
    import ddmix_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  fword_t step,
    output lo_pair_t lo
);

    localparam logic [QTR_N*AMP_W-1:0] QTR_TBL = build_quarter();

    fword_t            acc;
    logic [LUT_AW-1:0] p_sin;
    logic [LUT_AW-1:0] p_cos;

    function automatic logic signed [AMP_W-1:0] lut(input logic [LUT_AW-1:0] p);
        logic [QTR_AW-1:0] k;
        logic [AMP_W-1:0]  mag;
        k   = p[QTR_AW] ? ~p[QTR_AW-1:0] : p[QTR_AW-1:0];
        mag = QTR_TBL[k*AMP_W +: AMP_W];
        return p[LUT_AW-1] ? -signed'(mag) : signed'(mag);
    endfunction

    always_comb begin
        p_sin = acc[PHASE_W-1 -: LUT_AW];
        p_cos = p_sin + LUT_AW'(QTR_N);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            lo  <= '0;
        end else begin
            acc      <= clr ? '0 : acc + step;
            lo.sin_v <= lut(p_sin);
            lo.cos_v <= lut(p_cos);
        end
    end

    AST_TAG_ZEROES_PHASE: assert property (@(posedge clk) disable iff (rst)
        clr |=> acc == '0); // R5

endmodule

// File: rtl/ddmix_mix.sv
module ddmix_mix
    import ddmix_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic                       en,
    input  lo_pair_t                   lo,
    output iq_t                        iq
);

    logic signed [SAMPLE_W-1:0] x_q;
    logic [1:0]                 en_q;
    iq_t                        prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q  <= '0;
            en_q <= '0;
            prod <= '0;
            iq   <= '0;
        end else begin
            x_q    <= sample;
            en_q   <= {en_q[0], en};
            prod.i <= PROD_W'(x_q) * PROD_W'(lo.cos_v);
            prod.q <= PROD_W'(x_q) * PROD_W'(lo.sin_v);
            iq     <= en_q[1] ? prod : '0;
        end
    end

endmodule

// File: rtl/ddmix_top.sv
module ddmix_top
    import ddmix_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [SAMPLE_W-1:0] smp_in,
    input  logic                       ch_en,
    input  logic                       tag_in,
    input  logic                       dtag_in,
    input  logic                       cfg_wr,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [PHASE_W-1:0]         cfg_data,
    output logic signed [PROD_W-1:0]   i_out,
    output logic signed [PROD_W-1:0]   q_out
);

    lo_cfg_t  active;
    fword_t   step;
    lo_pair_t lo;
    iq_t      iq;

    ddmix_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .commit  (dtag_in),
        .active  (active)
    );

    assign step = active.fw[active.sel];

    ddmix_nco u_nco (
        .clk  (clk),
        .rst  (rst),
        .clr  (tag_in),
        .step (step),
        .lo   (lo)
    );

    ddmix_mix u_mix (
        .clk    (clk),
        .rst    (rst),
        .sample (smp_in),
        .en     (ch_en),
        .lo     (lo),
        .iq     (iq)
    );

    assign i_out = iq.i;
    assign q_out = iq.q;

    AST_OFF_GIVES_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(ch_en, 3) |-> (i_out == '0 && q_out == '0)); // R9

    AST_SAME_EDGE_BOTH: assert property (@(posedge clk) disable iff (rst)
        (tag_in && dtag_in) |=> (u_regs.active == $past(u_regs.hold) && u_nco.acc == '0)); // R6

endmodule

// File: tb/ddmix_top_bench.sv
module ddmix_top_bench;

    localparam int CLK_PER = 10;
    localparam real PI = 3.14159265358979323846;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [13:0] smp_in = '0;
    logic               ch_en = 1'b0;
    logic               tag_in = 1'b0;
    logic               dtag_in = 1'b0;
    logic               cfg_wr = 1'b0;
    logic [2:0]         cfg_addr = '0;
    logic [31:0]        cfg_data = '0;
    logic signed [29:0] i_out;
    logic signed [29:0] q_out;

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic signed [29:0] ei;
        logic signed [29:0] eq;
        string              req;
    } exp_t;

    exp_t sb[$];

    logic [31:0] m_acc;
    logic [31:0] m_hold [4];
    logic [31:0] m_act  [4];
    logic [1:0]  m_hsel;
    logic [1:0]  m_asel;

    always #(CLK_PER/2) clk = ~clk;

    ddmix_top u_ddmix_top (
        .clk      (clk),
        .rst      (rst),
        .smp_in   (smp_in),
        .ch_en    (ch_en),
        .tag_in   (tag_in),
        .dtag_in  (dtag_in),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .i_out    (i_out),
        .q_out    (q_out)
    );

    // R7 reference oscillator
    function automatic int lo_sin(input int p);
        int  pp;
        real r;
        pp = p % 1024;
        r  = 32767.0 * $sin(2.0 * PI * (real'(pp) + 0.5) / 1024.0);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    task automatic step(input int x, input logic en, input logic tg, input logic dt,
                        input logic wr, input logic [2:0] a, input logic [31:0] d,
                        input string req);
        exp_t        e;
        int          p;
        longint      c;
        longint      s;
        logic [31:0] nacc;
        @(negedge clk);
        smp_in   = 14'(x);
        ch_en    = en;
        tag_in   = tg;
        dtag_in  = dt;
        cfg_wr   = wr;
        cfg_addr = a;
        cfg_data = d;
        p = int'(m_acc[31:22]);
        c = longint'(lo_sin(p + 256));
        s = longint'(lo_sin(p));
        e.ei  = en ? 30'(longint'(x) * c) : '0;
        e.eq  = en ? 30'(longint'(x) * s) : '0;
        e.req = req;
        sb.push_back(e);
        nacc = tg ? 32'd0 : m_acc + m_act[m_asel];
        if (dt) begin
            for (int k = 0; k < 4; k++) m_act[k] = m_hold[k];
            m_asel = m_hsel;
        end
        if (wr) begin
            if (a < 3'd4) m_hold[a[1:0]] = d;
            else if (a == 3'd4) m_hsel = d[1:0];
        end
        m_acc = nacc;
    endtask

    task automatic run(input int n, input int x0, input int dx, input string req);
        for (int k = 0; k < n; k++)
            step(((x0 + k * dx) % 16384) - 8192, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0, req);
    endtask

    task automatic cfg(input logic [2:0] a, input logic [31:0] d, input string req);
        step(1234, 1'b1, 1'b0, 1'b0, 1'b1, a, d, req);
    endtask

    // monitor: sample away from the active edge
    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() >= 3) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (i_out !== e.ei || q_out !== e.eq) begin
                errors++;
                $display("FAIL %s: i=%0d q=%0d expected i=%0d q=%0d", e.req, i_out, q_out, e.ei, e.eq);
            end
        end
    end

    initial begin
        #(CLK_PER * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_acc = '0;
        m_hsel = '0;
        m_asel = '0;
        for (int k = 0; k < 4; k++) begin
            m_hold[k] = '0;
            m_act[k]  = '0;
        end
        // R1: reset state with busy inputs
        smp_in = 14'sd5000;
        ch_en  = 1'b1;
        repeat (4) begin
            @(negedge clk);
            checks++;
            if (i_out !== '0 || q_out !== '0) begin
                errors++;
                $display("FAIL R1: i=%0d q=%0d expected i=0 q=0", i_out, q_out);
            end
        end
        @(negedge clk);
        rst = 1'b0;
        // R1: active words are zero so phase holds at 0
        run(6, 9000, 37, "R1");
        // R3: holding writes do not reach the outputs
        cfg(3'd0, 32'h0100_0000, "R3");
        cfg(3'd1, 32'h0040_0000, "R3");
        cfg(3'd2, 32'h1234_5678, "R3");
        cfg(3'd3, 32'h0300_0000, "R3");
        run(6, 100, 511, "R3");
        // R4: commit, increment at commit edge uses old word
        step(700, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 32'd0, "R4");
        run(20, 3000, 701, "R2");
        // R4: write in the commit cycle stays in holding set
        step(-900, 1'b1, 1'b0, 1'b1, 1'b1, 3'd4, 32'd2, "R4");
        run(10, 50, 999, "R4");
        step(800, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 32'd0, "R4");
        run(25, 8000, 333, "R2");
        // R5: single tag clears phase
        step(4000, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 32'd0, "R5");
        run(10, 200, 1201, "R5");
        // R6: tag and commit together with new select
        cfg(3'd4, 32'd3, "R6");
        step(-4000, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 32'd0, "R6");
        run(12, 6000, 77, "R6");
        // R9: enable gating aligned with the sample
        for (int k = 0; k < 12; k++)
            step(3000 + k * 100, (k % 3) != 1, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0, "R9");
        // R7: step one table index per clock over the whole circle
        cfg(3'd1, 32'h0040_0000, "R7");
        cfg(3'd4, 32'd1, "R7");
        step(8191, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 32'd0, "R7");
        for (int k = 0; k < 1030; k++)
            step((k % 2) ? 8191 : -8192, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0, "R7");
        // R8, R10: full-scale samples with a fast oscillator
        cfg(3'd2, 32'h0A00_0001, "R8");
        cfg(3'd4, 32'd2, "R8");
        step(-8192, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 32'd0, "R8");
        for (int k = 0; k < 40; k++)
            step((k % 2) ? -8192 : 8191, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0, "R10");
        run(4, 0, 0, "R8");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule